// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block collects interrupt events from eight on-chip peripherals and turns them into a single request line for the CPU. Each peripheral sends a one-cycle pulse when its condition occurs. The pulse sets a matching bit in a sticky flag register. The flag register sits beside an 8-bit enable register, and both are read and written over a small register bus. A flag is set whether or not its enable is set, so software can poll flags with interrupts off.

The request line is raised when three conditions all hold. At least one flag must be set with its enable also set. The peripheral-interrupt gate input must be high. The global-interrupt gate input must be high. Both gate inputs come from a separate control register elsewhere in the chip.

One bit position in both registers is reserved and always reads as zero. The capture/compare source is ignored while that unit runs in PWM mode. Software may write 1 to a flag bit to raise an interrupt for test purposes. If a hardware event and a software clear reach the same flag in the same cycle, the event wins.

Top module: `pirq_ctrl`

## Requirements
- R1: After a synchronous reset, both the enable register and the flag register read 0x00 and `irq` is low.
- R2: The bit layout, from bit 7 down to bit 0, is: EEPROM write done, ADC conversion done, capture/compare, reserved, comparator change, oscillator failure, timer2 period match, timer1 overflow. Bit 4 is reserved in both registers. It always reads 0, and neither writes nor events can set it.
- R3: Writing with `reg_sel`=0 loads the enable register. `rd_data` shows the enable register while `reg_sel`=0 and the flag register while `reg_sel`=1.
- R4: A pulse on `evt[i]` sets flag bit i on the next clock edge. This happens even when enable bit i, `glb_en` and `per_en` are all 0.
- R5: A set flag bit stays set until software writes 0 to that bit with `reg_sel`=1.
- R6: Writing 1 to a flag bit with `reg_sel`=1 sets that bit.
- R7: If a software write of 0 and an event pulse hit the same flag bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when `glb_en`=1, `per_en`=1 and some implemented bit is set in both the flag register and the enable register.
- R9: While `pwm_mode`=1, a pulse on `evt[5]` does not set flag bit 5. The other sources and software writes to bit 5 are unaffected.
- R10: `irq` and `rd_data` are combinational from the registered state and the inputs. A flag set by an event is not visible before the clock edge that follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = enables, 1 = flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| evt | input | 8 | One-cycle event pulses, one per source |
| pwm_mode | input | 1 | Capture/compare unit is in PWM mode |
| glb_en | input | 1 | Global interrupt gate |
| per_en | input | 1 | Peripheral interrupt gate |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Events are first pulsed with every enable and gate off. This shows that flags latch on their own, separate from request generation. Flags are then cleared by software, set by software, and hit by an event and a clear in the same cycle, which tells the set priority apart from the clear priority. The request line is checked across all four combinations of the two gates, and with flag and enable patterns that miss each other. This shows that the request needs a matching pair of bits, not just any flag. Pulses on the reserved bit and on the capture/compare bit in PWM mode are mixed with pulses on other sources, so a source that is wrongly blocked can be told apart from one that is correctly blocked.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned SRC_W   = 8;
  localparam int unsigned BIT_T1  = 0;
  localparam int unsigned BIT_T2  = 1;
  localparam int unsigned BIT_OSC = 2;
  localparam int unsigned BIT_CMP = 3;
  localparam int unsigned BIT_RSV = 4;
  localparam int unsigned BIT_CC  = 5;
  localparam int unsigned BIT_ADC = 6;
  localparam int unsigned BIT_EEP = 7;

  localparam logic SEL_EN   = 1'b0;
  localparam logic SEL_FLAG = 1'b1;

  function automatic logic [SRC_W-1:0] impl_mask(input int unsigned rsv);
    logic [SRC_W-1:0] m;
    m = '1;
    m[rsv] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/pirq_enable_reg.sv
module pirq_enable_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] en_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (wr) q <= wr_data[i];
      end
      assign en_o[i] = q;
    end else begin : g_rsv
      assign en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pirq_src_gate.sv
module pirq_src_gate #(
  parameter int unsigned W = 8,
  parameter int unsigned CC_BIT = 5,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic [W-1:0] evt,
  input  logic         pwm_mode,
  output logic [W-1:0] set_ev
);
  localparam logic [W-1:0] CC_ONE = W'(1) << CC_BIT;
  logic [W-1:0] mode_mask;
  always_comb begin
    mode_mask = pwm_mode ? ~CC_ONE : '1;
    set_ev    = evt & mode_mask & IMPL_MASK;
  end
endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] set_ev,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (set_ev[i]) q <= 1'b1;
        else if (wr)        q <= wr_data[i];
      end
      assign flags_o[i] = q;
    end else begin : g_rsv
      assign flags_o[i] = 1'b0;
    end
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (set_ev != '0) |=> ((flags_o & $past(set_ev)) == $past(set_ev))); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!wr && set_ev == '0) |=> $stable(flags_o)); // R5
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((flags_o & ~$past(set_ev) & IMPL_MASK) == ($past(wr_data) & ~$past(set_ev) & IMPL_MASK))); // R7
endmodule

// File: rtl/pirq_req_gate.sv
module pirq_req_gate #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  input  logic         glb_en,
  input  logic         per_en,
  output logic         irq
);
  logic any_pend;
  always_comb begin
    any_pend = |(flags & en & IMPL_MASK);
    irq      = glb_en & per_en & any_pend;
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned W = SRC_W,
  parameter int unsigned RSV_BIT = BIT_RSV,
  parameter int unsigned CC_BIT = BIT_CC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         reg_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] evt,
  input  logic         pwm_mode,
  input  logic         glb_en,
  input  logic         per_en,
  output logic         irq
);
  localparam logic [W-1:0] IMPL = ~(W'(1) << RSV_BIT);

  logic         wr_en_reg, wr_flag_reg;
  logic [W-1:0] en_q, flags_q, set_ev;

  assign wr_en_reg   = wr_en && (reg_sel == SEL_EN);
  assign wr_flag_reg = wr_en && (reg_sel == SEL_FLAG);

  pirq_enable_reg #(.W(W), .IMPL_MASK(IMPL)) u_en (
    .clk(clk), .rst(rst), .wr(wr_en_reg), .wr_data(wr_data), .en_o(en_q));

  pirq_src_gate #(.W(W), .CC_BIT(CC_BIT), .IMPL_MASK(IMPL)) u_src (
    .evt(evt), .pwm_mode(pwm_mode), .set_ev(set_ev));

  pirq_flag_bank #(.W(W), .IMPL_MASK(IMPL)) u_flags (
    .clk(clk), .rst(rst), .wr(wr_flag_reg), .wr_data(wr_data),
    .set_ev(set_ev), .flags_o(flags_q));

  pirq_req_gate #(.W(W), .IMPL_MASK(IMPL)) u_req (
    .flags(flags_q), .en(en_q), .glb_en(glb_en), .per_en(per_en), .irq(irq));

  assign rd_data = (reg_sel == SEL_FLAG) ? flags_q : en_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (glb_en && per_en && ((flags_q & en_q) != '0))); // R8
  AST_PWM_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !wr_flag_reg && !flags_q[CC_BIT]) |=> !flags_q[CC_BIT]); // R9
endmodule

// File: tb/sim_pirq_ctrl.sv
module sim_pirq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic reg_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] evt = '0;
  logic pwm_mode = 1'b0;
  logic glb_en = 1'b0;
  logic per_en = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .evt(evt), .pwm_mode(pwm_mode), .glb_en(glb_en),
    .per_en(per_en), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic s, input logic [7:0] exp);
    reg_sel = s;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1;
    chk(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic bus_wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_reg("R1 enables", 1'b0, 8'h00);
    chk_reg("R1 flags", 1'b1, 8'h00);
    chk_irq("R1 irq", 1'b0);
  endtask

  task automatic t_enable_rw;
    bus_wr(1'b0, 8'hFF);
    chk_reg("R3 enable all (R2 bit4 zero)", 1'b0, 8'hEF);
    chk_reg("R3 flags untouched", 1'b1, 8'h00);
    bus_wr(1'b0, 8'h5A);
    chk_reg("R3 enable pattern", 1'b0, 8'h4A);
    bus_wr(1'b0, 8'h00);
    chk_reg("R3 enable clear", 1'b0, 8'h00);
  endtask

  task automatic t_reserved;
    bus_wr(1'b1, 8'h10);
    chk_reg("R2 write reserved flag", 1'b1, 8'h00);
    pulse(8'h10);
    chk_reg("R2 event on reserved", 1'b1, 8'h00);
    pulse(8'h18);
    chk_reg("R2 reserved beside comparator", 1'b1, 8'h08);
    bus_wr(1'b1, 8'h00);
  endtask

  task automatic t_event_no_enable;
    glb_en = 1'b0; per_en = 1'b0;
    @(negedge clk);
    evt = 8'h81;
    reg_sel = 1'b1;
    #1;
    chk("R10 flag not seen before edge", rd_data, 8'h00);
    @(negedge clk);
    evt = '0;
    chk_reg("R4 event sets with all off", 1'b1, 8'h81);
    chk_irq("R8 no irq with enables off", 1'b0);
    bus_wr(1'b1, 8'h00);
  endtask

  task automatic t_sticky;
    pulse(8'h04);
    repeat (5) @(negedge clk);
    chk_reg("R5 flag sticky", 1'b1, 8'h04);
    bus_wr(1'b1, 8'h00);
    chk_reg("R5 software clear", 1'b1, 8'h00);
  endtask

  task automatic t_sw_set;
    bus_wr(1'b1, 8'h22);
    chk_reg("R6 software set", 1'b1, 8'h22);
    bus_wr(1'b0, 8'h02);
    glb_en = 1'b1; per_en = 1'b1;
    chk_irq("R6 software irq", 1'b1);
    glb_en = 1'b0; per_en = 1'b0;
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_collision;
    bus_wr(1'b1, 8'h09);
    @(negedge clk);
    reg_sel = 1'b1; wr_data = 8'h00; wr_en = 1'b1; evt = 8'h08;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    chk_reg("R7 set beats clear", 1'b1, 8'h08);
    bus_wr(1'b1, 8'h00);
  endtask

  task automatic t_irq_gate;
    bus_wr(1'b1, 8'h40);
    bus_wr(1'b0, 8'h40);
    for (int g = 0; g < 4; g++) begin
      glb_en = g[0]; per_en = g[1];
      chk_irq("R8 gate matrix", (g == 3));
    end
    glb_en = 1'b0;
    chk_irq("R10 irq drops same cycle", 1'b0);
    glb_en = 1'b1;
    chk_irq("R10 irq rises same cycle", 1'b1);
    bus_wr(1'b0, 8'h80);
    chk_irq("R8 flag enable mismatch", 1'b0);
    bus_wr(1'b0, 8'h00);
    chk_irq("R8 enables off", 1'b0);
    glb_en = 1'b0; per_en = 1'b0;
    bus_wr(1'b1, 8'h00);
  endtask

  task automatic t_pwm;
    pwm_mode = 1'b1;
    pulse(8'h20);
    chk_reg("R9 cc ignored in pwm", 1'b1, 8'h00);
    pulse(8'h28);
    chk_reg("R9 other source still sets", 1'b1, 8'h08);
    bus_wr(1'b1, 8'h20);
    chk_reg("R9 software write in pwm", 1'b1, 8'h20);
    bus_wr(1'b1, 8'h00);
    pwm_mode = 1'b0;
    pulse(8'h20);
    chk_reg("R9 cc sets outside pwm", 1'b1, 8'h20);
    bus_wr(1'b1, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_rw();
    t_reserved();
    t_event_no_enable();
    t_sticky();
    t_sw_set();
    t_collision();
    t_irq_gate();
    t_pwm();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule